// File: doc/BRIEF.md
# ECC Error Status and Interrupt Registers

This block is the software-visible control and status register set of an ECC-protected memory controller. It sits behind a single-beat AXI4-Lite slave port. The ECC datapath drives it with one-cycle pulses for correctable and uncorrectable errors and with the address of the access that failed. The block keeps one sticky flag per error class and records the failing address of the first uncorrectable error. It also drives an interrupt line that is masked per error class by an enable register. Status recording does not depend on the enables.

For test, software can load fault-injection masks: a data mask as wide as the protected word and a check-bit mask. The block presents these to the write datapath. They are applied to exactly one write beat and then clear themselves. The injection registers exist only when the build-time parameter `INJECT_EN` is 1. The number of 32-bit data mask words follows `DATA_W`, so a 64-bit build has two words and a 128-bit build has four. Writes are full-word; byte strobes are not carried.

Top module: `ecc_err_csr`

## Requirements
- R1: The status register at offset 0x004 reads with the correctable flag in bit 1 and the uncorrectable flag in bit 0. Bits 31:2 read as zero, and both flags are 0 after reset.
- R2: An error pulse sets its flag at the next clock edge, and the flag stays at 1 through later cycles until software clears it.
- R3: Writing the status register clears each flag whose write-data bit is 1 and leaves each flag whose bit is 0 unchanged. No write can set a flag.
- R4: When an error pulse and a clearing write hit the same flag in the same cycle, the flag stays at 1.
- R5: Flags are recorded whatever the value of the interrupt enable register, including when both enables are 0.
- R6: The interrupt enable register at offset 0x008 holds the correctable enable in bit 1 and the uncorrectable enable in bit 0, reads back as written, and resets to 0. `irq` is high exactly when some flag and its enable are both 1, and it follows a flag change by one cycle after the error pulse.
- R7: The first failing address is latched from `err_addr` only in the cycle the uncorrectable flag goes from 0 to 1, and is held while that flag stays set. Its bits 31:0 read at 0x2C0 and bits 63:32 at 0x2C4 (zero when `ADDR_W` is 32 or less). It resets to 0.
- R8: Fault-inject data word k (bits 32k+31:32k) is written at 0x300 + 4k for k below `DATA_W`/32, and the check-bit mask at 0x380. Both appear on `inj_data` and `inj_chk`. They read back as zero, reset to zero, and are zero when `INJECT_EN` is 0.
- R9: Loaded inject masks stay in place until a cycle with `dp_wr_beat` high. After that cycle both masks are zero.
- R10: Reads of reserved offsets return zero with an OKAY response. Writes to reserved offsets or to the read-only address registers change nothing.
- R11: A write is taken in the cycle both address and data valids are high. `s_bvalid` rises at the next edge and holds until `s_bready`. Read data appears with `s_rvalid` one cycle after the address is taken and stays stable until `s_rready`. Both responses are OKAY (2'b00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | AXI_AW | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | AXI_AW | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| ce_pulse | input | 1 | Correctable error seen this cycle |
| ue_pulse | input | 1 | Uncorrectable error seen this cycle |
| err_addr | input | ADDR_W | Address of the failing access |
| irq | output | 1 | Masked error interrupt |
| dp_wr_beat | input | 1 | Write datapath consumes a beat this cycle |
| inj_data | output | DATA_W | Data bits to flip on the next write beat |
| inj_chk | output | ECC_W | Check bits to flip on the next write beat |

## Verification
A flag that is lost, or that is set by a write, shows in the next status read and on `irq` one cycle after the pulse, because the interrupt has no register of its own. A capture enable that fires on every uncorrectable pulse instead of only the first shows as a changed failing-address read after a second error while the flag is still set. A set/clear priority inversion shows only when an error and a clearing write meet in the same cycle, so the bench makes them coincide on purpose. An inject mask that fails to clear, or clears early, shows directly on `inj_data` and `inj_chk` in the cycle after `dp_wr_beat`.

// File: rtl/ecc_csr_pkg.sv
package ecc_csr_pkg;

  localparam logic [11:0] OFS_STATUS   = 12'h004;
  localparam logic [11:0] OFS_IRQEN    = 12'h008;
  localparam logic [11:0] OFS_FFA_LO   = 12'h2C0;
  localparam logic [11:0] OFS_FFA_HI   = 12'h2C4;
  localparam logic [11:0] OFS_INJ_BASE = 12'h300;
  localparam logic [11:0] OFS_INJ_CHK  = 12'h380;

  // bit 1 = correctable, bit 0 = uncorrectable
  typedef struct packed {
    logic ce;
    logic ue;
  } err_pair_t;

  function automatic logic [31:0] pair_word(err_pair_t p);
    return {30'b0, p};
  endfunction

  // set has priority over clear
  function automatic logic sticky_next(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction

  function automatic logic irq_of(err_pair_t flags, err_pair_t en);
    return (flags.ce & en.ce) | (flags.ue & en.ue);
  endfunction

  function automatic logic [11:0] inj_word_ofs(int k);
    return OFS_INJ_BASE + 12'(4 * k);
  endfunction

endpackage

// File: rtl/ecc_csr_axil.sv
module ecc_csr_axil #(
  parameter int AXI_AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AXI_AW-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [31:0]       s_wdata,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [AXI_AW-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [31:0]       s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic              wr_en,
  output logic [AXI_AW-1:0] wr_addr,
  output logic [31:0]       wr_data,
  output logic [AXI_AW-1:0] rd_addr,
  input  logic [31:0]       rd_data
);

  logic rd_take;

  assign wr_en     = s_awvalid & s_wvalid & ~s_bvalid;
  assign s_awready = wr_en;
  assign s_wready  = wr_en;
  assign wr_addr   = {s_awaddr[AXI_AW-1:2], 2'b00};
  assign wr_data   = s_wdata;
  assign s_bresp   = 2'b00;

  assign s_arready = ~s_rvalid;
  assign rd_take   = s_arvalid & s_arready;
  assign rd_addr   = {s_araddr[AXI_AW-1:2], 2'b00};
  assign s_rresp   = 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_bvalid <= 1'b0;
    end else if (wr_en) begin
      s_bvalid <= 1'b1;
    end else if (s_bready) begin
      s_bvalid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_rvalid <= 1'b0;
      s_rdata  <= '0;
    end else if (rd_take) begin
      s_rvalid <= 1'b1;
      s_rdata  <= rd_data;
    end else if (s_rready) begin
      s_rvalid <= 1'b0;
    end
  end

  assert_bvalid_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid && !s_bready |=> s_bvalid);
  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata));
  assert_wr_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> s_bvalid);

endmodule

// File: rtl/ecc_csr_status.sv
module ecc_csr_status
  import ecc_csr_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_pulse,
  input  logic              ue_pulse,
  input  logic [ADDR_W-1:0] err_addr,
  input  err_pair_t         clr,
  input  logic              en_wr,
  input  err_pair_t         en_data,
  output err_pair_t         flags,
  output err_pair_t         enables,
  output logic [ADDR_W-1:0] ffa,
  output logic              irq
);

  logic ue_rise;
  assign ue_rise = ue_pulse & ~flags.ue;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
    end else begin
      flags.ce <= sticky_next(flags.ce, ce_pulse, clr.ce);
      flags.ue <= sticky_next(flags.ue, ue_pulse, clr.ue);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enables <= '0;
    end else if (en_wr) begin
      enables <= en_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ffa <= '0;
    end else if (ue_rise) begin
      ffa <= err_addr;
    end
  end

  assign irq = irq_of(flags, enables);

  assert_ce_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ce_pulse |=> flags.ce);
  assert_ue_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    flags.ue && !clr.ue |=> flags.ue);
  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ce_pulse && clr.ce |=> flags.ce);
  assert_ue_set_noen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ue_pulse && !enables.ue |=> flags.ue);
  assert_irq_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ce_pulse && enables.ce && !en_wr |=> irq);
  assert_ffa_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ue_rise |=> ffa == $past(err_addr));
  assert_ffa_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flags.ue |=> $stable(ffa));

endmodule

// File: rtl/ecc_csr_inject.sv
module ecc_csr_inject
  import ecc_csr_pkg::*;
#(
  parameter int DATA_W    = 128,
  parameter int ECC_W     = 16,
  parameter bit INJECT_EN = 1'b1,
  parameter int AXI_AW    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AXI_AW-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              dp_wr_beat,
  output logic [DATA_W-1:0] inj_data,
  output logic [ECC_W-1:0]  inj_chk
);

  localparam int NWORDS = DATA_W / 32;

  generate
    if (INJECT_EN) begin : g_inj
      for (genvar k = 0; k < NWORDS; k++) begin : g_word
        logic hit;
        assign hit = wr_en && (wr_addr == AXI_AW'(inj_word_ofs(k)));
        always_ff @(posedge clk) begin
          if (!rst_n) begin
            inj_data[32*k +: 32] <= '0;
          end else if (hit) begin
            inj_data[32*k +: 32] <= wr_data;
          end else if (dp_wr_beat) begin
            inj_data[32*k +: 32] <= '0;
          end
        end
      end

      logic chk_hit;
      assign chk_hit = wr_en && (wr_addr == AXI_AW'(OFS_INJ_CHK));
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          inj_chk <= '0;
        end else if (chk_hit) begin
          inj_chk <= wr_data[ECC_W-1:0];
        end else if (dp_wr_beat) begin
          inj_chk <= '0;
        end
      end
    end else begin : g_noinj
      logic unused_inj;
      assign unused_inj = ^{clk, rst_n, wr_en, wr_addr, wr_data, dp_wr_beat};
      assign inj_data   = '0;
      assign inj_chk    = '0;
    end
  endgenerate

  assert_inj_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dp_wr_beat && !wr_en |=> inj_data == '0 && inj_chk == '0);
  assert_inj_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !dp_wr_beat && !wr_en |=> $stable(inj_data) && $stable(inj_chk));

endmodule

// File: rtl/ecc_err_csr.sv
module ecc_err_csr
  import ecc_csr_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int DATA_W    = 128,
  parameter int ECC_W     = 16,
  parameter bit INJECT_EN = 1'b1,
  parameter int AXI_AW    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AXI_AW-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [31:0]       s_wdata,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [AXI_AW-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [31:0]       s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  input  logic              ce_pulse,
  input  logic              ue_pulse,
  input  logic [ADDR_W-1:0] err_addr,
  output logic              irq,
  input  logic              dp_wr_beat,
  output logic [DATA_W-1:0] inj_data,
  output logic [ECC_W-1:0]  inj_chk
);

  logic              wr_en;
  logic [AXI_AW-1:0] wr_addr;
  logic [31:0]       wr_data;
  logic [AXI_AW-1:0] rd_addr;
  logic [31:0]       rd_data;
  err_pair_t         clr;
  err_pair_t         flags;
  err_pair_t         enables;
  logic              en_wr;
  logic [ADDR_W-1:0] ffa;
  logic [63:0]       ffa_ext;

  ecc_csr_axil #(.AXI_AW(AXI_AW)) u_axil (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  assign clr   = (wr_en && wr_addr == AXI_AW'(OFS_STATUS)) ? err_pair_t'(wr_data[1:0]) : '0;
  assign en_wr = wr_en && (wr_addr == AXI_AW'(OFS_IRQEN));

  ecc_csr_status #(.ADDR_W(ADDR_W)) u_status (
    .clk(clk), .rst_n(rst_n),
    .ce_pulse(ce_pulse), .ue_pulse(ue_pulse), .err_addr(err_addr),
    .clr(clr), .en_wr(en_wr), .en_data(err_pair_t'(wr_data[1:0])),
    .flags(flags), .enables(enables), .ffa(ffa), .irq(irq)
  );

  ecc_csr_inject #(
    .DATA_W(DATA_W), .ECC_W(ECC_W), .INJECT_EN(INJECT_EN), .AXI_AW(AXI_AW)
  ) u_inject (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dp_wr_beat(dp_wr_beat), .inj_data(inj_data), .inj_chk(inj_chk)
  );

  assign ffa_ext = 64'(ffa);

  // write-only and reserved offsets read as zero
  always_comb begin
    rd_data = '0;
    if (rd_addr == AXI_AW'(OFS_STATUS))      rd_data = pair_word(flags);
    else if (rd_addr == AXI_AW'(OFS_IRQEN))  rd_data = pair_word(enables);
    else if (rd_addr == AXI_AW'(OFS_FFA_LO)) rd_data = ffa_ext[31:0];
    else if (rd_addr == AXI_AW'(OFS_FFA_HI)) rd_data = ffa_ext[63:32];
  end

  assert_status_reserved_R1: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid && $rose(s_rvalid) && $past(rd_addr) == AXI_AW'(OFS_STATUS) |-> s_rdata[31:2] == '0);
  assert_no_irq_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !flags.ce && !flags.ue |-> !irq);

endmodule

// File: tb/ecc_err_csr_tb.sv
module ecc_err_csr_tb;

  localparam int ADDR_W = 64;
  localparam int DATA_W = 128;
  localparam int ECC_W  = 16;
  localparam int AXI_AW = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [AXI_AW-1:0] s_awaddr = '0;
  logic              s_awvalid = 1'b0;
  logic              s_awready;
  logic [31:0]       s_wdata = '0;
  logic              s_wvalid = 1'b0;
  logic              s_wready;
  logic [1:0]        s_bresp;
  logic              s_bvalid;
  logic              s_bready = 1'b0;
  logic [AXI_AW-1:0] s_araddr = '0;
  logic              s_arvalid = 1'b0;
  logic              s_arready;
  logic [31:0]       s_rdata;
  logic [1:0]        s_rresp;
  logic              s_rvalid;
  logic              s_rready = 1'b0;
  logic              ce_pulse = 1'b0;
  logic              ue_pulse = 1'b0;
  logic [ADDR_W-1:0] err_addr = '0;
  logic              irq;
  logic              dp_wr_beat = 1'b0;
  logic [DATA_W-1:0] inj_data;
  logic [ECC_W-1:0]  inj_chk;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        prev_rv = 1'b0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  ecc_err_csr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ECC_W(ECC_W),
                .INJECT_EN(1'b1), .AXI_AW(AXI_AW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
    .ce_pulse(ce_pulse), .ue_pulse(ue_pulse), .err_addr(err_addr), .irq(irq),
    .dp_wr_beat(dp_wr_beat), .inj_data(inj_data), .inj_chk(inj_chk)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compares each new read response against the scoreboard queue
  always @(negedge clk) begin
    if (s_rvalid && !prev_rv) begin
      if (exp_q.size() == 0) begin
        check("R11 unexpected read", 64'(s_rdata), 64'hDEAD);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, 64'(s_rdata), 64'(e));
        check("R11 rresp", 64'(s_rresp), 64'd0);
      end
    end
    prev_rv = s_rvalid;
  end

  task automatic axi_write(input logic [11:0] a, input logic [31:0] d, input bit with_ce = 1'b0);
    @(negedge clk);
    s_awaddr = a; s_wdata = d; s_awvalid = 1'b1; s_wvalid = 1'b1; ce_pulse = with_ce;
    @(negedge clk);
    s_awvalid = 1'b0; s_wvalid = 1'b0; ce_pulse = 1'b0;
    check("R11 bvalid", 64'(s_bvalid), 64'd1);
    check("R11 bresp", 64'(s_bresp), 64'd0);
    @(negedge clk);
    check("R11 bvalid held", 64'(s_bvalid), 64'd1);
    s_bready = 1'b1;
    @(negedge clk);
    s_bready = 1'b0;
  endtask

  task automatic axi_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    s_araddr = a; s_arvalid = 1'b1;
    @(negedge clk);
    s_arvalid = 1'b0;
    @(negedge clk);
    s_rready = 1'b1;
    @(negedge clk);
    s_rready = 1'b0;
  endtask

  task automatic pulse(input bit ce, input bit ue, input logic [63:0] a);
    @(negedge clk);
    ce_pulse = ce; ue_pulse = ue; err_addr = a;
    @(negedge clk);
    ce_pulse = 1'b0; ue_pulse = 1'b0; err_addr = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check("R6 irq after reset", 64'(irq), 64'd0);
    check("R8 inj_data after reset", inj_data[63:0], 64'd0);
    check("R8 inj_chk after reset", 64'(inj_chk), 64'd0);
    axi_read(12'h004, 32'h0, "R1 status reset");
    axi_read(12'h008, 32'h0, "R6 enable reset");
    axi_read(12'h2C0, 32'h0, "R7 ffa lo reset");
    axi_read(12'h2C4, 32'h0, "R7 ffa hi reset");

    // sticky set with enables off
    pulse(1'b1, 1'b0, 64'h0);
    check("R5 irq masked", 64'(irq), 64'd0);
    repeat (3) @(negedge clk);
    axi_read(12'h004, 32'h2, "R2 ce flag sticky");
    pulse(1'b0, 1'b1, 64'h0000_00AB_CDEF_0123);
    axi_read(12'h004, 32'h3, "R1 both flags");
    axi_read(12'h2C0, 32'hCDEF_0123, "R7 ffa lo capture");
    axi_read(12'h2C4, 32'h0000_00AB, "R7 ffa hi capture");
    pulse(1'b0, 1'b1, 64'h1111_2222_3333_4444);
    axi_read(12'h2C0, 32'hCDEF_0123, "R7 ffa held on second error");

    // write-1-to-clear
    axi_write(12'h004, 32'h0);
    axi_read(12'h004, 32'h3, "R3 write zero keeps flags");
    axi_write(12'h004, 32'h2);
    axi_read(12'h004, 32'h1, "R3 clear ce only");

    // interrupt masking
    axi_write(12'h008, 32'h2);
    axi_read(12'h008, 32'h2, "R6 enable readback");
    check("R6 irq off: ue set but masked", 64'(irq), 64'd0);
    pulse(1'b1, 1'b0, 64'h0);
    check("R6 irq one cycle after ce", 64'(irq), 64'd1);

    // set wins over clear in same cycle
    axi_write(12'h004, 32'h3, 1'b1);
    axi_read(12'h004, 32'h2, "R4 set beats clear");
    check("R4 irq stays", 64'(irq), 64'd1);

    // relatch after ue cleared
    pulse(1'b0, 1'b1, 64'h1111_2222_3333_4444);
    axi_read(12'h2C0, 32'h3333_4444, "R7 relatch lo");
    axi_read(12'h2C4, 32'h1111_2222, "R7 relatch hi");
    axi_write(12'h008, 32'h1);
    check("R6 irq from ue", 64'(irq), 64'd1);
    axi_write(12'h004, 32'h1);
    check("R6 irq drops with ue clear", 64'(irq), 64'd0);
    axi_read(12'h004, 32'h2, "R3 ce left set");
    axi_write(12'h004, 32'h2);
    axi_write(12'h004, 32'h3);
    axi_read(12'h004, 32'h0, "R3 write cannot set");

    // reserved and read-only offsets
    axi_write(12'h100, 32'hFFFF_FFFF);
    axi_read(12'h100, 32'h0, "R10 reserved reads zero");
    axi_write(12'h2C0, 32'hFFFF_FFFF);
    axi_read(12'h2C0, 32'h3333_4444, "R10 ffa write ignored");
    axi_read(12'h3F0, 32'h0, "R10 other reserved");
    axi_read(12'h008, 32'h1, "R10 enable unchanged");

    // fault injection
    axi_write(12'h300, 32'hA0A0_0001);
    axi_write(12'h304, 32'hA0A0_0002);
    axi_write(12'h308, 32'hA0A0_0003);
    axi_write(12'h30C, 32'hA0A0_0004);
    axi_write(12'h380, 32'h0000_ABCD);
    check("R8 inj data lo", inj_data[63:0], 64'hA0A0_0002_A0A0_0001);
    check("R8 inj data hi", inj_data[127:64], 64'hA0A0_0004_A0A0_0003);
    check("R8 inj chk", 64'(inj_chk), 64'hABCD);
    axi_read(12'h300, 32'h0, "R8 inj data reads zero");
    axi_read(12'h380, 32'h0, "R8 inj chk reads zero");
    check("R9 masks held before beat", inj_data[63:0], 64'hA0A0_0002_A0A0_0001);
    @(negedge clk);
    dp_wr_beat = 1'b1;
    @(negedge clk);
    dp_wr_beat = 1'b0;
    check("R9 data cleared after beat", inj_data[63:0] | inj_data[127:64], 64'd0);
    check("R9 chk cleared after beat", 64'(inj_chk), 64'd0);

    repeat (3) @(negedge clk);
    check("R11 all reads answered", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule